// File: doc/BRIEF.md
# Narrow-bus to wide-memory read/write bridge

This block sits on a 32-bit AHB system bus as a slave and forwards every transfer to one port of a shared SDRAM controller whose data path is 64 bits wide. The controller port offers only two kinds of access: a read of a fixed run of consecutive 64-bit beats, and a single 64-bit write. Each access begins with a request that is held until the controller grants it, and ends with a done pulse. The SDRAM command sequencing stays inside the controller.

Reads fetch a whole aligned line of four 32-bit words, two 64-bit beats, into a local buffer. The addressed word is then returned from that buffer. Later beats of the same sequential AHB burst that stay inside that line are served straight from the buffer with no wait state. A non-sequential transfer, or a sequential one that moves into another line, starts a new line fetch. A 32-bit write cannot be expressed on the wide port. The bridge therefore reads the enclosing 64-bit word, replaces the addressed half with the bus data, and writes the merged word back. Writes are always single accesses.

While any controller access is in flight the bridge stretches the AHB data phase by holding its ready output low. Every response is OKAY. IDLE and BUSY transfers never touch the controller.

Top module: `ahb_sdram_bridge`

## Requirements
- R1: While reset is asserted and right after it, `hreadyout` is 1, `hresp` is 0 and `mem_req` is 0.
- R2: A read of byte address A returns bits [63:32] of 64-bit memory word A>>3 when A[2] is 1, and bits [31:0] when A[2] is 0.
- R3: A write to byte address A issues one single-beat read (`mem_burst`=0, `mem_we`=0) at A with bits [2:0] cleared. It then issues one single-beat write (`mem_we`=1) of the same word, in which only the half selected by A[2] (as in R2) is replaced by the bus data.
- R4: Every NONSEQ read issues exactly one controller handshake. That handshake is a line read with `mem_burst`=1, `mem_we`=0, at an address whose low four bits are zero. It returns two 64-bit beats, the lower address first.
- R5: A sequential read burst of up to four words that stays inside one aligned 16-byte line costs exactly one handshake. Every beat after the first completes with zero wait states.
- R6: A sequential read beat whose address enters a different 16-byte line than the buffered one starts a new line fetch. An 8-word aligned burst therefore costs exactly two handshakes.
- R7: A write request (`mem_we`=1) never has `mem_burst`=1, and a write burst of N words causes N reads and N writes on the controller port.
- R8: IDLE and BUSY transfers complete with zero wait states and cause no controller handshake.
- R9: `hreadyout` is 0 whenever `mem_req` is 1 and until the access that completes the pending transfer is done. `hresp` is always 0 (OKAY).
- R10: Once raised, `mem_req` stays high with `mem_addr` and `mem_we` unchanged until a cycle in which `mem_gnt` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsel | input | 1 | Slave select |
| haddr | input | HADDR_W | Byte address of the address phase |
| htrans | input | 2 | Transfer type: 0 IDLE, 1 BUSY, 2 NONSEQ, 3 SEQ |
| hwrite | input | 1 | 1 for a write transfer |
| hwdata | input | HDATA_W | Write data of the data phase |
| hready | input | 1 | Bus-wide ready, high when the previous data phase ends |
| hrdata | output | HDATA_W | Read data |
| hreadyout | output | 1 | This slave's ready; low stretches the data phase |
| hresp | output | 1 | Response, always OKAY (0) |
| mem_req | output | 1 | Access request to the controller, held until granted |
| mem_gnt | input | 1 | Grant for the pending request |
| mem_we | output | 1 | 1 for a single-beat write access |
| mem_burst | output | 1 | 1 for a line read, 0 for a single-beat access |
| mem_addr | output | HADDR_W | Byte address of the access, beat or line aligned |
| mem_wdata | output | MDATA_W | Merged 64-bit write word |
| mem_rdata | input | MDATA_W | Read beat from the controller |
| mem_rvalid | input | 1 | Read beat valid |
| mem_done | input | 1 | Pulse marking the end of the access |

## Verification
The bench sweeps single NONSEQ reads over every word of a 512-byte memory image, so a wrong half select or a missing refetch shows up as a value error. It also counts handshakes, which must be exactly one per read. Aligned four-word bursts at every line show whether hits really cost no wait state. A two-word burst in the upper half of a line, a four-word burst that straddles two lines and an eight-word burst tell a correct line-boundary test apart from a plain beat counter. BUSY slots inside a burst and idle stretches show that they do not disturb the buffer and cause no access. Single writes to both halves of many words, followed by a write burst and a full read-back, show that the other half of each word survives the merge and that no write ever goes out as a burst.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

   localparam logic [1:0] TR_IDLE   = 2'b00;
   localparam logic [1:0] TR_BUSY   = 2'b01;
   localparam logic [1:0] TR_NONSEQ = 2'b10;
   localparam logic [1:0] TR_SEQ    = 2'b11;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_HIT,
      ST_FILL_REQ,
      ST_FILL,
      ST_RMW_REQ,
      ST_RMW_RD,
      ST_WR_REQ,
      ST_WR,
      ST_DONE
   } bridge_state_e;

endpackage

// File: rtl/bridge_addr_phase.sv
module bridge_addr_phase
   import bridge_pkg::*;
#(
   parameter int HADDR_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hsel,
   input  logic               hready,
   input  logic [1:0]         htrans,
   input  logic               hwrite,
   input  logic [HADDR_W-1:0] haddr,
   output logic               acc_valid,
   output logic               acc_write,
   output logic               acc_seq,
   output logic [HADDR_W-1:0] dp_addr
);

   assign acc_valid = hsel && hready && (htrans == TR_NONSEQ || htrans == TR_SEQ);
   assign acc_write = hwrite;
   assign acc_seq   = (htrans == TR_SEQ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dp_addr <= '0;
      end else if (acc_valid) begin
         dp_addr <= haddr;
      end
   end

endmodule

// File: rtl/bridge_line_buf.sv
module bridge_line_buf #(
   parameter int HADDR_W    = 32,
   parameter int HDATA_W    = 32,
   parameter int MDATA_W    = 64,
   parameter int LINE_WORDS = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          fill_start,
   input  logic                          inval,
   input  logic                          beat_we,
   input  logic                          fill_done,
   input  logic [MDATA_W-1:0]            beat_data,
   input  logic [HADDR_W-1:0]            haddr,
   input  logic [$clog2(LINE_WORDS)-1:0] rd_idx,
   output logic                          hit,
   output logic [HDATA_W-1:0]            rd_word
);

   localparam int WPB        = MDATA_W / HDATA_W;
   localparam int LINE_BEATS = LINE_WORDS / WPB;
   localparam int BYTE_LSB   = $clog2(HDATA_W / 8);
   localparam int LINE_LSB   = $clog2(LINE_WORDS) + BYTE_LSB;
   localparam int BIDX_W     = $clog2(LINE_BEATS);
   localparam logic [HADDR_W-1:0] LINE_MASK = HADDR_W'((64'd1 << LINE_LSB) - 64'd1);

   logic                 valid_q;
   logic [HADDR_W-1:0]   tag_q;
   logic [BIDX_W-1:0]    fill_idx;
   logic [MDATA_W-1:0]   beats [LINE_BEATS];
   logic [HDATA_W-1:0]   words [LINE_WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q  <= 1'b0;
         tag_q    <= '0;
         fill_idx <= '0;
      end else begin
         if (fill_start) begin
            valid_q  <= 1'b0;
            tag_q    <= haddr & ~LINE_MASK;
            fill_idx <= '0;
         end else begin
            if (inval) begin
               valid_q <= 1'b0;
            end
            if (fill_done) begin
               valid_q <= 1'b1;
            end
            if (beat_we) begin
               fill_idx <= fill_idx + BIDX_W'(1);
            end
         end
      end
   end

   for (genvar b = 0; b < LINE_BEATS; b++) begin : g_beat
      always_ff @(posedge clk) begin
         if (beat_we && fill_idx == BIDX_W'(b)) begin
            beats[b] <= beat_data;
         end
      end
      for (genvar k = 0; k < WPB; k++) begin : g_word
         assign words[b*WPB + k] = beats[b][k*HDATA_W +: HDATA_W];
      end
   end

   assign hit     = valid_q && ((haddr & ~LINE_MASK) == tag_q);
   assign rd_word = words[rd_idx];

endmodule

// File: rtl/bridge_ctrl.sv
module bridge_ctrl
   import bridge_pkg::*;
#(
   parameter int HADDR_W    = 32,
   parameter int HDATA_W    = 32,
   parameter int MDATA_W    = 64,
   parameter int LINE_WORDS = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc_valid,
   input  logic               acc_write,
   input  logic               acc_seq,
   input  logic               lb_hit,
   input  logic [HADDR_W-1:0] dp_addr,
   input  logic [HDATA_W-1:0] hwdata,
   input  logic               mem_gnt,
   input  logic               mem_rvalid,
   input  logic               mem_done,
   input  logic [MDATA_W-1:0] mem_rdata,
   output logic               hreadyout,
   output logic               mem_req,
   output logic               mem_we,
   output logic               mem_burst,
   output logic [HADDR_W-1:0] mem_addr,
   output logic [MDATA_W-1:0] mem_wdata,
   output logic               lb_fill_start,
   output logic               lb_inval,
   output logic               lb_beat_we,
   output logic               lb_fill_done
);

   localparam int WPB      = MDATA_W / HDATA_W;
   localparam int BYTE_LSB = $clog2(HDATA_W / 8);
   localparam int BEAT_LSB = $clog2(MDATA_W / 8);
   localparam int LINE_LSB = $clog2(LINE_WORDS) + BYTE_LSB;
   localparam int LANE_W   = BEAT_LSB - BYTE_LSB;
   localparam logic [HADDR_W-1:0] BEAT_MASK = HADDR_W'((64'd1 << BEAT_LSB) - 64'd1);
   localparam logic [HADDR_W-1:0] LINE_MASK = HADDR_W'((64'd1 << LINE_LSB) - 64'd1);

   bridge_state_e        state, nxt;
   logic                 ready_st;
   logic [LANE_W-1:0]    lane_sel;
   logic [MDATA_W-1:0]   merged;
   logic [MDATA_W-1:0]   wbuf;

   assign ready_st = (state == ST_IDLE) || (state == ST_HIT) || (state == ST_DONE);

   always_comb begin
      nxt = state;
      case (state)
         ST_IDLE, ST_HIT, ST_DONE: begin
            if (!acc_valid) begin
               nxt = ST_IDLE;
            end else if (acc_write) begin
               nxt = ST_RMW_REQ;
            end else if (acc_seq && lb_hit) begin
               nxt = ST_HIT;
            end else begin
               nxt = ST_FILL_REQ;
            end
         end
         ST_FILL_REQ: if (mem_gnt)  nxt = ST_FILL;
         ST_FILL:     if (mem_done) nxt = ST_DONE;
         ST_RMW_REQ:  if (mem_gnt)  nxt = ST_RMW_RD;
         ST_RMW_RD:   if (mem_done) nxt = ST_WR_REQ;
         ST_WR_REQ:   if (mem_gnt)  nxt = ST_WR;
         ST_WR:       if (mem_done) nxt = ST_DONE;
         default:     nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
      end else begin
         state <= nxt;
      end
   end

   // merge of the bus word into the fetched 64-bit word, one lane per bus word
   assign lane_sel = dp_addr[BEAT_LSB-1:BYTE_LSB];
   for (genvar k = 0; k < WPB; k++) begin : g_lane
      assign merged[k*HDATA_W +: HDATA_W] =
         (lane_sel == LANE_W'(k)) ? hwdata : mem_rdata[k*HDATA_W +: HDATA_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbuf <= '0;
      end else if (state == ST_RMW_RD && mem_rvalid) begin
         wbuf <= merged;
      end
   end

   assign hreadyout = ready_st;
   assign mem_req   = (state == ST_FILL_REQ) || (state == ST_RMW_REQ) || (state == ST_WR_REQ);
   assign mem_we    = (state == ST_WR_REQ);
   assign mem_burst = (state == ST_FILL_REQ);
   assign mem_addr  = mem_burst ? (dp_addr & ~LINE_MASK) : (dp_addr & ~BEAT_MASK);
   assign mem_wdata = wbuf;

   assign lb_fill_start = ready_st && acc_valid && !acc_write && !(acc_seq && lb_hit);
   assign lb_inval      = ready_st && acc_valid && acc_write;
   assign lb_beat_we    = (state == ST_FILL) && mem_rvalid;
   assign lb_fill_done  = (state == ST_FILL) && mem_done;

endmodule

// File: rtl/ahb_sdram_bridge.sv
module ahb_sdram_bridge #(
   parameter int HADDR_W    = 32,
   parameter int HDATA_W    = 32,
   parameter int MDATA_W    = 64,
   parameter int LINE_WORDS = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hsel,
   input  logic [HADDR_W-1:0] haddr,
   input  logic [1:0]         htrans,
   input  logic               hwrite,
   input  logic [HDATA_W-1:0] hwdata,
   input  logic               hready,
   output logic [HDATA_W-1:0] hrdata,
   output logic               hreadyout,
   output logic               hresp,
   output logic               mem_req,
   input  logic               mem_gnt,
   output logic               mem_we,
   output logic               mem_burst,
   output logic [HADDR_W-1:0] mem_addr,
   output logic [MDATA_W-1:0] mem_wdata,
   input  logic [MDATA_W-1:0] mem_rdata,
   input  logic               mem_rvalid,
   input  logic               mem_done
);

   localparam int WPB        = MDATA_W / HDATA_W;
   localparam int LINE_BEATS = LINE_WORDS / (WPB > 0 ? WPB : 1);
   localparam int BYTE_LSB   = $clog2(HDATA_W / 8);
   localparam int LINE_LSB   = $clog2(LINE_WORDS) + BYTE_LSB;

   // elaboration-time parameter checks
   if (HDATA_W < 8 || (HDATA_W & (HDATA_W - 1)) != 0) begin : g_bad_hdata
      $error("HDATA_W must be a power of two of at least 8");
   end
   if (MDATA_W % HDATA_W != 0 || WPB < 2 || (WPB & (WPB - 1)) != 0) begin : g_bad_mdata
      $error("MDATA_W must be a power-of-two multiple (>=2) of HDATA_W");
   end
   if ((LINE_WORDS & (LINE_WORDS - 1)) != 0 || LINE_BEATS < 2) begin : g_bad_line
      $error("LINE_WORDS must be a power of two covering at least two wide beats");
   end
   if (HADDR_W <= LINE_LSB) begin : g_bad_addr
      $error("HADDR_W too small for the line size");
   end

   logic               acc_valid, acc_write, acc_seq;
   logic [HADDR_W-1:0] dp_addr;
   logic               lb_hit, lb_fill_start, lb_inval, lb_beat_we, lb_fill_done;

   bridge_addr_phase #(
      .HADDR_W (HADDR_W)
   ) addr_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .hsel      (hsel),
      .hready    (hready),
      .htrans    (htrans),
      .hwrite    (hwrite),
      .haddr     (haddr),
      .acc_valid (acc_valid),
      .acc_write (acc_write),
      .acc_seq   (acc_seq),
      .dp_addr   (dp_addr)
   );

   bridge_line_buf #(
      .HADDR_W    (HADDR_W),
      .HDATA_W    (HDATA_W),
      .MDATA_W    (MDATA_W),
      .LINE_WORDS (LINE_WORDS)
   ) line_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .fill_start (lb_fill_start),
      .inval      (lb_inval),
      .beat_we    (lb_beat_we),
      .fill_done  (lb_fill_done),
      .beat_data  (mem_rdata),
      .haddr      (haddr),
      .rd_idx     (dp_addr[LINE_LSB-1:BYTE_LSB]),
      .hit        (lb_hit),
      .rd_word    (hrdata)
   );

   bridge_ctrl #(
      .HADDR_W    (HADDR_W),
      .HDATA_W    (HDATA_W),
      .MDATA_W    (MDATA_W),
      .LINE_WORDS (LINE_WORDS)
   ) ctrl_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .acc_valid     (acc_valid),
      .acc_write     (acc_write),
      .acc_seq       (acc_seq),
      .lb_hit        (lb_hit),
      .dp_addr       (dp_addr),
      .hwdata        (hwdata),
      .mem_gnt       (mem_gnt),
      .mem_rvalid    (mem_rvalid),
      .mem_done      (mem_done),
      .mem_rdata     (mem_rdata),
      .hreadyout     (hreadyout),
      .mem_req       (mem_req),
      .mem_we        (mem_we),
      .mem_burst     (mem_burst),
      .mem_addr      (mem_addr),
      .mem_wdata     (mem_wdata),
      .lb_fill_start (lb_fill_start),
      .lb_inval      (lb_inval),
      .lb_beat_we    (lb_beat_we),
      .lb_fill_done  (lb_fill_done)
   );

   assign hresp = 1'b0;

endmodule

// File: rtl/bridge_checker.sv
module bridge_checker #(
   parameter int HADDR_W    = 32,
   parameter int HDATA_W    = 32,
   parameter int MDATA_W    = 64,
   parameter int LINE_WORDS = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               hsel,
   input logic               hready,
   input logic [1:0]         htrans,
   input logic               hreadyout,
   input logic               mem_req,
   input logic               mem_gnt,
   input logic               mem_we,
   input logic               mem_burst,
   input logic [HADDR_W-1:0] mem_addr
);

   localparam int BYTE_LSB = $clog2(HDATA_W / 8);
   localparam int BEAT_LSB = $clog2(MDATA_W / 8);
   localparam int LINE_LSB = $clog2(LINE_WORDS) + BYTE_LSB;

   assert_wait_while_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !hreadyout);

   assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   assert_write_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> !mem_burst);

   assert_line_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_burst) |-> (mem_addr[LINE_LSB-1:0] == '0 && !mem_we));

   assert_beat_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_burst) |-> (mem_addr[BEAT_LSB-1:0] == '0));

   assert_idle_nowait_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hsel && hready && hreadyout && (htrans == 2'b00 || htrans == 2'b01))
      |=> (hreadyout && !mem_req));

endmodule

bind ahb_sdram_bridge bridge_checker #(
   .HADDR_W    (HADDR_W),
   .HDATA_W    (HDATA_W),
   .MDATA_W    (MDATA_W),
   .LINE_WORDS (LINE_WORDS)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .hsel      (hsel),
   .hready    (hready),
   .htrans    (htrans),
   .hreadyout (hreadyout),
   .mem_req   (mem_req),
   .mem_gnt   (mem_gnt),
   .mem_we    (mem_we),
   .mem_burst (mem_burst),
   .mem_addr  (mem_addr)
);

// File: tb/ahb_sdram_bridge_tb_top.sv
module ahb_sdram_bridge_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int MEM_WORDS  = 64;      // 64-bit words in the model
   localparam int BUS_WORDS  = 2 * MEM_WORDS;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hsel = 1'b0;
   logic [31:0] haddr = '0;
   logic [1:0]  htrans = 2'b00;
   logic        hwrite = 1'b0;
   logic [31:0] hwdata = '0;
   logic        hready;
   logic [31:0] hrdata;
   logic        hreadyout, hresp;
   logic        mem_req, mem_we, mem_burst;
   logic        mem_gnt = 1'b0, mem_rvalid = 1'b0, mem_done = 1'b0;
   logic [31:0] mem_addr;
   logic [63:0] mem_wdata;
   logic [63:0] mem_rdata = '0;

   assign hready = hreadyout;

   always #(CLK_PERIOD/2) clk = ~clk;

   ahb_sdram_bridge dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .hsel       (hsel),
      .haddr      (haddr),
      .htrans     (htrans),
      .hwrite     (hwrite),
      .hwdata     (hwdata),
      .hready     (hready),
      .hrdata     (hrdata),
      .hreadyout  (hreadyout),
      .hresp      (hresp),
      .mem_req    (mem_req),
      .mem_gnt    (mem_gnt),
      .mem_we     (mem_we),
      .mem_burst  (mem_burst),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_rdata  (mem_rdata),
      .mem_rvalid (mem_rvalid),
      .mem_done   (mem_done)
   );

   int checks = 0;
   int fails  = 0;
   int hs_cnt = 0, wr_cnt = 0, wr_burst_bad = 0, gnt_lat = 0;
   int idle_waits = 0, resp_bad = 0, req_ready_bad = 0, req_drop_bad = 0;
   int waits [16];
   logic [63:0] mem64 [MEM_WORDS];
   logic [31:0] ref32 [BUS_WORDS];

   function automatic logic [31:0] seed_word(int w);
      return (32'(w) * 32'h9E37_79B9) ^ 32'h1234_5678;
   endfunction

   function automatic logic [31:0] wr_word(int seed, int i);
      return 32'hC0DE_0000 ^ (32'(seed) << 8) ^ 32'(i);
   endfunction

   task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual %h expected %h", rq, act, exp);
      end
   endtask

   // controller model: grant after gnt_lat cycles, data one cycle after grant
   initial begin
      logic [31:0] a;
      logic        we, bu;
      logic [63:0] wd;
      forever begin
         @(negedge clk);
         if (rst_n && mem_req) begin
            repeat (gnt_lat) @(negedge clk);
            mem_gnt = 1'b1;
            a = mem_addr; we = mem_we; bu = mem_burst; wd = mem_wdata;
            hs_cnt++;
            if (we) wr_cnt++;
            if (we && bu) wr_burst_bad++;
            @(negedge clk);
            mem_gnt = 1'b0;
            @(negedge clk);
            if (we) begin
               mem64[a[8:3]] = wd;
               mem_done = 1'b1;
               @(negedge clk);
               mem_done = 1'b0;
            end else begin
               for (int b = 0; b < (bu ? 2 : 1); b++) begin
                  mem_rvalid = 1'b1;
                  mem_rdata  = mem64[a[8:3] + 6'(b)];
                  mem_done   = (b == (bu ? 1 : 0));
                  @(negedge clk);
               end
               mem_rvalid = 1'b0;
               mem_done   = 1'b0;
            end
         end
      end
   end

   // port monitor for R9 / R10
   initial begin
      logic prev_req = 1'b0, prev_gnt = 1'b0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (hresp !== 1'b0) resp_bad++;
            if (mem_req && hreadyout) req_ready_bad++;
            if (prev_req && !prev_gnt && !mem_req) req_drop_bad++;
         end
         prev_req = mem_req;
         prev_gnt = mem_gnt;
      end
   end

   // one INCR burst of n words; a BUSY slot is inserted before beat busy_at
   task automatic burst(input int a0, input int n, input bit wr, input int busy_at,
                        input int seed, input string rq);
      int i = 0, cur = -1;
      bit real_a, bdone = 0;
      for (int k = 0; k < 16; k++) waits[k] = 0;
      while (i < n || cur >= 0) begin
         @(negedge clk);
         real_a = 1'b0;
         hsel   = 1'b1;
         hwrite = wr;
         if (i < n) begin
            haddr = 32'(a0 + 4*i);
            if (i == busy_at && !bdone) begin
               htrans = 2'b01;
            end else begin
               htrans = (i == 0) ? 2'b10 : 2'b11;
               real_a = 1'b1;
            end
         end else begin
            htrans = 2'b00;
         end
         if (cur >= 0) hwdata = wr_word(seed, cur);
         if (hreadyout) begin
            if (cur >= 0) begin
               if (wr) ref32[(a0 >> 2) + cur] = wr_word(seed, cur);
               else check(hrdata == ref32[(a0 >> 2) + cur], rq,
                          64'(hrdata), 64'(ref32[(a0 >> 2) + cur]));
            end
            if (htrans == 2'b01) bdone = 1'b1;
            cur = real_a ? i : -1;
            if (real_a) i++;
         end else if (cur >= 0) begin
            waits[cur]++;
         end else begin
            idle_waits++;
         end
      end
      @(negedge clk);
      htrans = 2'b00;
   endtask

   initial begin
      int h0, w0;
      for (int j = 0; j < MEM_WORDS; j++) mem64[j] = {seed_word(2*j+1), seed_word(2*j)};
      for (int w = 0; w < BUS_WORDS; w++) ref32[w] = seed_word(w);

      // R1: reset state
      repeat (3) @(negedge clk);
      check(hreadyout === 1'b1, "R1 hreadyout in reset", 64'(hreadyout), 64'd1);
      check(mem_req === 1'b0, "R1 mem_req in reset", 64'(mem_req), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(hreadyout === 1'b1 && hresp === 1'b0 && mem_req === 1'b0, "R1 after reset",
            {61'd0, hreadyout, hresp, mem_req}, 64'd4);

      // R2/R4: single NONSEQ reads of every word, one handshake each
      for (int w = 0; w < BUS_WORDS; w++) begin
         gnt_lat = w % 3;
         h0 = hs_cnt;
         burst(4*w, 1, 1'b0, -1, 0, "R2 single read");
         check(hs_cnt - h0 == 1, "R4 one handshake per NONSEQ", 64'(hs_cnt - h0), 64'd1);
      end

      // R4: a repeated NONSEQ read to the same word refetches
      h0 = hs_cnt;
      burst(20, 1, 1'b0, -1, 0, "R2 repeat read");
      burst(20, 1, 1'b0, -1, 0, "R2 repeat read");
      check(hs_cnt - h0 == 2, "R4 NONSEQ discards line", 64'(hs_cnt - h0), 64'd2);

      // R5: aligned four-word bursts at every line
      for (int l = 0; l < 32; l++) begin
         gnt_lat = l % 3;
         h0 = hs_cnt;
         burst(16*l, 4, 1'b0, -1, 0, "R5 line burst data");
         check(hs_cnt - h0 == 1, "R5 one handshake per line", 64'(hs_cnt - h0), 64'd1);
         check(waits[1] + waits[2] + waits[3] == 0, "R5 zero-wait hits",
               64'(waits[1] + waits[2] + waits[3]), 64'd0);
      end

      // R5: two-word burst in the upper half of a line
      h0 = hs_cnt;
      burst(16*5 + 8, 2, 1'b0, -1, 0, "R5 short burst data");
      check(hs_cnt - h0 == 1 && waits[1] == 0, "R5 short burst cost",
            64'(hs_cnt - h0), 64'd1);

      // R6: line crossings
      h0 = hs_cnt;
      burst(16*7 + 8, 4, 1'b0, -1, 0, "R6 straddling data");
      check(hs_cnt - h0 == 2, "R6 straddling burst handshakes", 64'(hs_cnt - h0), 64'd2);
      check(waits[1] == 0 && waits[2] > 0 && waits[3] == 0, "R6 wait only at new line",
            {waits[1][15:0], waits[2][15:0], waits[3][15:0], 16'd0}, 64'd1);
      h0 = hs_cnt;
      burst(16*10, 8, 1'b0, -1, 0, "R6 eight-word data");
      check(hs_cnt - h0 == 2, "R6 eight-word handshakes", 64'(hs_cnt - h0), 64'd2);

      // R8: BUSY inside a burst, then an idle stretch
      idle_waits = 0;
      h0 = hs_cnt;
      burst(16*12, 4, 1'b0, 2, 0, "R8 burst with BUSY data");
      check(hs_cnt - h0 == 1 && idle_waits == 0, "R8 BUSY no access no wait",
            64'(hs_cnt - h0), 64'd1);
      h0 = hs_cnt;
      w0 = 0;
      for (int c = 0; c < 6; c++) begin
         @(negedge clk);
         htrans = 2'b00;
         hsel   = 1'b1;
         if (!hreadyout) w0++;
      end
      check(hs_cnt == h0 && w0 == 0, "R8 IDLE no access no wait", 64'(hs_cnt - h0 + w0), 64'd0);

      // R3: single writes to both halves, other half preserved
      gnt_lat = 1;
      for (int w = 0; w < 16; w++) begin
         h0 = hs_cnt;
         w0 = wr_cnt;
         burst(4*(2*w + (w % 2)), 1, 1'b1, -1, w, "R3 write");
         check(hs_cnt - h0 == 2 && wr_cnt - w0 == 1, "R3 read then write",
               64'(hs_cnt - h0), 64'd2);
         check(mem64[w] == {ref32[2*w+1], ref32[2*w]}, "R3 merged word",
               mem64[w], {ref32[2*w+1], ref32[2*w]});
      end

      // R7: write burst goes out as single accesses
      h0 = hs_cnt;
      w0 = wr_cnt;
      burst(16*20 + 4, 4, 1'b1, -1, 77, "R7 write burst");
      check(hs_cnt - h0 == 8 && wr_cnt - w0 == 4, "R7 N reads and N writes",
            64'(hs_cnt - h0), 64'd8);
      check(wr_burst_bad == 0, "R7 no burst writes", 64'(wr_burst_bad), 64'd0);

      // R2/R3: read back the whole image
      gnt_lat = 0;
      for (int l = 0; l < 32; l++) burst(16*l, 4, 1'b0, -1, 0, "R2 final read-back");

      check(resp_bad == 0, "R9 hresp OKAY", 64'(resp_bad), 64'd0);
      check(req_ready_bad == 0, "R9 no ready while requesting", 64'(req_ready_bad), 64'd0);
      check(req_drop_bad == 0, "R10 request held to grant", 64'(req_drop_bad), 64'd0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule